// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter

This block is a 16-bit up-counter. It counts either an instruction-rate tick from inside the chip or rising edges on one of two external clock pins. A power-of-two prescaler of 1, 2, 4 or 8 sits in front of the counter. The count is read as a 16-bit word and written one byte at a time. A sticky flag records when the count wraps from its maximum back to zero, and a dedicated input clears that flag.

All logic runs on a single fast system clock. The selected external pin passes through a two-flop synchroniser and a rising-edge detector, and the resulting one-cycle pulses drive the prescaler. In external mode, software picks one of two paths from the prescaler output to the counter:

- **Synchronised path:** adds one register stage after the prescaler and is gated by the sleep indication.
- **Direct path:** feeds the prescaler output straight to the counter and keeps counting through sleep.

In the synchronised path during sleep, the prescaler keeps advancing on pin edges but the counter holds.

Top module: `pscl_timer`

## Requirements
- R1: With `src_ext_i`=0, every cycle in which `tick_i`=1 is a counting event. At prescale 1 the count changes on that same clock edge. `bypass_sync_i` has no effect in this mode.
- R2: With `src_ext_i`=1, counting events are rising edges of the selected pin: `ext_a_i` when `pin_sel_i`=1, `ext_b_i` when `pin_sel_i`=0. Edges on the pin that is not selected have no effect.
- R3: `pscl_i` selects the division ratio: 2'b00 divides by 1, 2'b01 by 2, 2'b10 by 4 and 2'b11 by 8. The count increments on the last event of each group of that many events.
- R4: Take a pin level first sampled high at clock edge k, with prescale 1. With `bypass_sync_i`=1 the count increments at edge k+2. With `bypass_sync_i`=0 the extra stage after the prescaler delays the increment to edge k+3.
- R5: With `src_ext_i`=1, `bypass_sync_i`=0 and `sleep_i`=1, the count does not change. The prescaler still advances on pin edges during that time.
- R6: With `src_ext_i`=1 and `bypass_sync_i`=1, the count keeps advancing while `sleep_i`=1.
- R7: An increment from 16'hFFFF wraps the count to 16'h0000 and sets `ovf_o`. `ovf_o` stays set until it is cleared.
- R8: `ovf_clr_i`=1 clears `ovf_o` on the next edge. The clear wins over a wrap in the same cycle.
- R9: `wr_lo_i` loads `wr_data_i` into bits 7:0 of the count, and `wr_hi_i` loads it into bits 15:8. A write overrides an increment in the same cycle and resets the prescaler.
- R10: With `run_en_i`=0, the count and the prescaler hold their values.
- R11: After reset, the count is 0, `ovf_o` is 0 and the prescaler is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Internal instruction-rate tick |
| ext_a_i | input | 1 | External clock pin A (oscillator input) |
| ext_b_i | input | 1 | External clock pin B (clock input) |
| run_en_i | input | 1 | Timer on/off |
| src_ext_i | input | 1 | 0 selects the internal tick, 1 selects the external pin |
| bypass_sync_i | input | 1 | 1 selects the direct external path, 0 the synchronised path |
| pin_sel_i | input | 1 | 1 selects pin A, 0 selects pin B |
| pscl_i | input | 2 | Prescale select |
| sleep_i | input | 1 | Sleep indication |
| wr_lo_i | input | 1 | Write the low count byte |
| wr_hi_i | input | 1 | Write the high count byte |
| wr_data_i | input | 8 | Byte write data |
| ovf_clr_i | input | 1 | Clear the overflow flag |
| count_o | output | 16 | Current count |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bench builds the block with its defaults: two synchroniser stages, a 2-bit prescale field and two 8-bit count bytes. With these values all four division ratios can be reached, and the full count width can be preset by two byte writes. That makes the wrap from 16'hFFFF a one-event test. The two-stage synchroniser fixes the pin-to-count latency at a cycle count small enough to sample exactly, so the one-cycle gap between the direct and synchronised paths is checked at the precise edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned CNT_BYTES = 2;
  localparam int unsigned PS_SEL_W  = 2;
  localparam int unsigned SYNC_STG  = 2;

  typedef enum logic [1:0] {
    PATH_INT      = 2'd0,
    PATH_EXT_RAW  = 2'd1,
    PATH_EXT_SYNC = 2'd2
  } path_e;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= pin_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b0;
      else         sync_q[g] <= sync_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o) else $error("rise pulse longer than one cycle"); // R2
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             evt_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tc_o
);
  localparam int unsigned PS_W = (1 << SEL_W) - 1;

  logic [PS_W-1:0] ps_q;
  logic [PS_W-1:0] mask;
  logic            step;

  // bit i of the mask takes part in the terminal count when ratio exceeds 2^i
  for (genvar g = 0; g < PS_W; g++) begin : g_mask
    assign mask[g] = (32'(sel_i) > g);
  end

  assign step = en_i & evt_i;
  assign tc_o = step & ((ps_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ps_q <= '0;
    else if (clr_i) ps_q <= '0;
    else if (step)  ps_q <= ps_q + 1'b1;
  end

  AST_PS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(ps_q)) else $error("prescaler moved while off"); // R10
  AST_PS_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (ps_q == '0)) else $error("prescaler not cleared by write"); // R9
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NBYTES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     inc_i,
  input  logic                     wr_lo_i,
  input  logic                     wr_hi_i,
  input  logic [BYTE_W-1:0]        wr_data_i,
  input  logic                     ovf_clr_i,
  output logic [BYTE_W*NBYTES-1:0] cnt_o,
  output logic                     ovf_o
);
  localparam int unsigned CNT_W = BYTE_W * NBYTES;

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             wr_any;
  logic             wrap;

  assign wr_any = wr_lo_i | wr_hi_i;
  assign wrap   = inc_i & (&cnt_q) & ~wr_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (wr_any) begin
      if (wr_lo_i) cnt_q[BYTE_W-1:0]     <= wr_data_i;
      if (wr_hi_i) cnt_q[CNT_W-1:BYTE_W] <= {(CNT_W-BYTE_W)/BYTE_W{wr_data_i}};
    end else if (inc_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (ovf_clr_i) ovf_q <= 1'b0;
    else if (wrap)      ovf_q <= 1'b1;
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  AST_OVF_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_any && !ovf_clr_i && cnt_q == {CNT_W{1'b1}}) |=> (ovf_q && cnt_q == '0))
    else $error("wrap did not set flag"); // R7
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ovf_clr_i) |=> ovf_q) else $error("flag dropped"); // R7
  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_clr_i |=> !ovf_q) else $error("clear lost"); // R8
  AST_WR_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && !wr_hi_i) |=> (cnt_q[BYTE_W-1:0] == $past(wr_data_i)
                               && cnt_q[CNT_W-1:BYTE_W] == $past(cnt_q[CNT_W-1:BYTE_W])))
    else $error("low byte write"); // R9
endmodule

// File: rtl/pscl_timer.sv
module pscl_timer
  import tmr_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          tick_i,
  input  logic                          ext_a_i,
  input  logic                          ext_b_i,
  input  logic                          run_en_i,
  input  logic                          src_ext_i,
  input  logic                          bypass_sync_i,
  input  logic                          pin_sel_i,
  input  logic [PS_SEL_W-1:0]           pscl_i,
  input  logic                          sleep_i,
  input  logic                          wr_lo_i,
  input  logic                          wr_hi_i,
  input  logic [BYTE_W-1:0]             wr_data_i,
  input  logic                          ovf_clr_i,
  output logic [BYTE_W*CNT_BYTES-1:0]   count_o,
  output logic                          ovf_o
);
  logic  pin_raw;
  logic  ext_rise;
  logic  ps_evt;
  logic  ps_clr;
  logic  tc;
  logic  sync_q;
  logic  inc;
  path_e path;

  assign pin_raw = pin_sel_i ? ext_a_i : ext_b_i;

  tmr_edge_sync #(.STAGES(SYNC_STG)) i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_raw),
    .rise_o (ext_rise)
  );

  assign ps_evt = src_ext_i ? ext_rise : tick_i;
  assign ps_clr = wr_lo_i | wr_hi_i;

  tmr_prescaler #(.SEL_W(PS_SEL_W)) i_pscl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run_en_i),
    .evt_i  (ps_evt),
    .clr_i  (ps_clr),
    .sel_i  (pscl_i),
    .tc_o   (tc)
  );

  always_comb begin
    if (!src_ext_i)         path = PATH_INT;
    else if (bypass_sync_i) path = PATH_EXT_RAW;
    else                    path = PATH_EXT_SYNC;
  end

  // resync stage after the prescaler; sleep stops it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sync_q <= 1'b0;
    else if (ps_clr) sync_q <= 1'b0;
    else             sync_q <= tc & ~sleep_i & (path == PATH_EXT_SYNC);
  end

  always_comb begin
    unique case (path)
      PATH_INT, PATH_EXT_RAW: inc = tc;
      PATH_EXT_SYNC:          inc = sync_q & ~sleep_i;
      default:                inc = 1'b0;
    endcase
    inc = inc & run_en_i;
  end

  tmr_count #(.BYTE_W(BYTE_W), .NBYTES(CNT_BYTES)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (inc),
    .wr_lo_i   (wr_lo_i),
    .wr_hi_i   (wr_hi_i),
    .wr_data_i (wr_data_i),
    .ovf_clr_i (ovf_clr_i),
    .cnt_o     (count_o),
    .ovf_o     (ovf_o)
  );

  AST_SLEEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_ext_i && !bypass_sync_i && sleep_i && !wr_lo_i && !wr_hi_i) |=> $stable(count_o))
    else $error("count moved in sleep"); // R5
  AST_RUN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_en_i && !wr_lo_i && !wr_hi_i) |=> $stable(count_o))
    else $error("count moved while off"); // R10
  AST_INT_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src_ext_i && run_en_i && tick_i && pscl_i == '0 && !wr_lo_i && !wr_hi_i)
      |=> (count_o == $past(count_o) + 1'b1))
    else $error("internal tick missed"); // R1
endmodule

// File: tb/test_pscl_timer.sv
module test_pscl_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, ext_a = 1'b0, ext_b = 1'b0;
  logic        run_en = 1'b0, src_ext = 1'b0, bypass = 1'b0, pin_sel = 1'b0;
  logic [1:0]  pscl = 2'b00;
  logic        sleep = 1'b0, wr_lo = 1'b0, wr_hi = 1'b0, ovf_clr = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [15:0] count;
  logic        ovf;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pscl_timer i_pscl_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ext_a_i(ext_a), .ext_b_i(ext_b),
    .run_en_i(run_en), .src_ext_i(src_ext), .bypass_sync_i(bypass), .pin_sel_i(pin_sel),
    .pscl_i(pscl), .sleep_i(sleep), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi),
    .wr_data_i(wr_data), .ovf_clr_i(ovf_clr), .count_o(count), .ovf_o(ovf));

  // {pscl, ticks, expected count}: R3 ratios, R1 internal counting
  localparam logic [15:0] VEC [8] = '{
    {2'b00, 6'd5,  8'd5}, {2'b01, 6'd5,  8'd2}, {2'b10, 6'd9,  8'd2},
    {2'b11, 6'd7,  8'd0}, {2'b11, 6'd16, 8'd2}, {2'b10, 6'd4,  8'd1},
    {2'b01, 6'd1,  8'd0}, {2'b00, 6'd33, 8'd33}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic write16(input logic [15:0] v);
    @(negedge clk); wr_lo = 1'b1; wr_hi = 1'b1; wr_data = v[7:0];
    @(negedge clk); wr_lo = 1'b1; wr_hi = 1'b0; wr_data = v[7:0];
    @(negedge clk); wr_lo = 1'b0; wr_hi = 1'b1; wr_data = v[15:8];
    @(negedge clk); wr_hi = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic pulse(input bit on_a);
    @(negedge clk);
    if (on_a) ext_a = 1'b1; else ext_b = 1'b1;
    repeat (3) @(negedge clk);
    if (on_a) ext_a = 1'b0; else ext_b = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 count", 32'(count), 32'h0);
    chk("R11 ovf", 32'(ovf), 32'h0);
    rst_n = 1'b1;
    run_en = 1'b1;

    for (int v = 0; v < 8; v++) begin
      pscl = VEC[v][15:14];
      write16(16'h0000);
      ticks(int'(VEC[v][13:8]));
      chk("R3 R1 table", 32'(count), 32'(VEC[v][7:0]));
    end

    // R1: same-edge update, sync select ignored in internal mode
    pscl = 2'b00; bypass = 1'b0; write16(16'h0010);
    @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
    chk("R1 sync ignored", 32'(count), 32'h11);
    bypass = 1'b1;
    @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
    chk("R1 bypass", 32'(count), 32'h12);

    // R2: pin select
    src_ext = 1'b1; bypass = 1'b1; pin_sel = 1'b1; write16(16'h0000);
    pulse(1'b1); pulse(1'b0);
    chk("R2 pin a", 32'(count), 32'h1);
    pin_sel = 1'b0;
    pulse(1'b0); pulse(1'b1);
    chk("R2 pin b", 32'(count), 32'h2);
    pscl = 2'b10; write16(16'h0000);
    for (int i = 0; i < 8; i++) pulse(1'b0);
    chk("R3 ext div4", 32'(count), 32'h2);

    // R4: latency direct vs synchronised
    pscl = 2'b00; bypass = 1'b1; write16(16'h0000);
    @(negedge clk); ext_b = 1'b1;
    repeat (3) @(posedge clk); @(negedge clk);
    chk("R4 direct k+2", 32'(count), 32'h1);
    ext_b = 1'b0; repeat (4) @(negedge clk);
    bypass = 1'b0; write16(16'h0000);
    @(negedge clk); ext_b = 1'b1;
    repeat (3) @(posedge clk); @(negedge clk);
    chk("R4 sync not yet", 32'(count), 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R4 sync k+3", 32'(count), 32'h1);
    ext_b = 1'b0; repeat (4) @(negedge clk);

    // R5: sleep holds count, prescaler keeps moving
    pscl = 2'b01; write16(16'h0000);
    sleep = 1'b1; pulse(1'b0);
    chk("R5 hold", 32'(count), 32'h0);
    sleep = 1'b0; pulse(1'b0);
    chk("R5 prescaler advanced", 32'(count), 32'h1);
    pscl = 2'b00; sleep = 1'b1; pulse(1'b0); pulse(1'b0);
    chk("R5 hold div1", 32'(count), 32'h1);

    // R6: direct path runs in sleep
    bypass = 1'b1; pulse(1'b0); pulse(1'b0);
    chk("R6 sleep direct", 32'(count), 32'h3);
    sleep = 1'b0;

    // R7 / R8: overflow
    src_ext = 1'b0; write16(16'hFFFF); ticks(1);
    chk("R7 wrap count", 32'(count), 32'h0);
    chk("R7 flag", 32'(ovf), 32'h1);
    ticks(2);
    chk("R7 sticky", 32'(ovf), 32'h1);
    @(negedge clk); ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    chk("R8 clear", 32'(ovf), 32'h0);
    write16(16'hFFFF);
    @(negedge clk); tick = 1'b1; ovf_clr = 1'b1;
    @(negedge clk); tick = 1'b0; ovf_clr = 1'b0;
    chk("R8 clear wins", 32'(ovf), 32'h0);
    chk("R8 wrapped", 32'(count), 32'h0);

    // R9: writes override and reset prescaler
    write16(16'h1234);
    chk("R9 both bytes", 32'(count), 32'h1234);
    @(negedge clk); tick = 1'b1; wr_lo = 1'b1; wr_data = 8'hA5;
    @(negedge clk); tick = 1'b0; wr_lo = 1'b0;
    chk("R9 write beats inc", 32'(count), 32'h12A5);
    pscl = 2'b01; ticks(1);
    @(negedge clk); wr_hi = 1'b1; wr_data = 8'h00; @(negedge clk); wr_hi = 1'b0;
    ticks(1);
    chk("R9 prescaler cleared", 32'(count), 32'h00A5);

    // R10: off holds
    pscl = 2'b00; run_en = 1'b0; ticks(3);
    chk("R10 off", 32'(count), 32'h00A5);
    run_en = 1'b1; ticks(1);
    chk("R10 on again", 32'(count), 32'h00A6);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule